// File: doc/BRIEF.md
# Descriptor Ring Receive DMA

This block moves received frames from a byte stream into buffer memory. Software lays out a circular ring of two-word descriptors. Each descriptor names one fixed-size buffer and carries an ownership flag. The engine takes a descriptor only while that flag hands it to the engine. It fills the buffer four bytes per memory word. When the buffer is done, it rewrites the descriptor's control word with the byte count, and for the final buffer of a frame also the receive status and the total frame length. It then clears the ownership flag so that software can take the buffer.

A frame longer than one buffer continues in the next descriptor. A new frame always starts in a fresh descriptor at buffer offset zero. When the engine meets a descriptor it does not own, it discards the rest of the frame, bumps a drop counter, and polls the same descriptor again when the next frame arrives.

Descriptor `i` sits at word address `base + 2*i`. Word 0 holds the buffer word address. Word 1 is the control word: bit 31 ownership (1 = engine), bit 30 last-buffer flag, bits 29:26 status, bits 25:16 bytes used, bits 15:0 frame length. Memory is word addressed; a read returns data with `mem_rvalid` one cycle after the request.

Top module: `rxd_ring_dma`

## Requirements
- R1: After reset `rx_ready` and `mem_req` are low and `drop_count` is zero.
- R2: At the start of a frame, or when a frame continues into the next descriptor, the engine first reads the control word at `base+2*idx+1`. Only when bit 31 of that word is 1 does it read the buffer address at `base+2*idx`.
- R3: If bit 31 of the control word is 0 at the start of a frame, the whole frame is consumed with no memory write and `drop_count` rises by one. The same descriptor is read again for the next frame.
- R4: Byte k of a buffer is stored in word `buf+k/4`, bits `8*(k%4)+7 : 8*(k%4)`. A partially filled final word is written with zeros in its unused upper byte lanes.
- R5: Each buffer holds exactly BUF_BYTES bytes. A longer frame continues at offset zero of the next descriptor's buffer.
- R6: A new frame never shares a buffer with the previous frame; it starts at offset zero of the next descriptor.
- R7: A filled buffer that is not the frame's last gets the control word: ownership 0, last 0, status 0, used BUF_BYTES, length 0.
- R8: The last buffer of a frame gets the control word: ownership 0, last 1, status from `rx_status` at the final byte, used = bytes in that buffer, length = total frame bytes. A frame ending exactly at a buffer boundary reports used = BUF_BYTES.
- R9: Every control-word writeback is done in two consecutive writes to the same address. The first has bit 31 = 1 and all other fields final. The second differs only in bit 31, which is 0.
- R10: After descriptor `cfg_ring_size-1` the ring index wraps to 0.
- R11: If a frame continues into a descriptor the engine does not own, the remaining bytes are discarded without writes, `drop_count` rises by one, and that descriptor's control word is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | AW | Word address of descriptor 0 |
| cfg_ring_size | input | clog2(MAX_DESC+1) | Number of descriptors in the ring |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the final one of its frame |
| rx_status | input | 4 | Frame status, valid with the final byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| drop_count | output | CW | Frames lost for want of a descriptor |

## Verification
The bench builds the engine with 16-byte buffers, a 10-bit word address space and room for eight descriptors, and runs a four-entry ring. The small buffers let short frames cover several cases: spanning two buffers, ending exactly on a buffer boundary, wrapping the ring, and losing ownership mid-frame, all within a few hundred cycles. The bench's memory model logs every read and write, so the order of descriptor reads and the two-step ownership release are checked directly.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int STW = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_WT_CTL, S_RD_ADDR, S_WT_ADDR,
    S_FILL, S_WB_FIELDS, S_WB_OWN, S_DROP
  } rxd_state_e;

  // control word: own[31] last[30] status[29:26] used[25:16] length[15:0]
  function automatic logic [31:0] ctl_pack(logic own, logic last, logic [STW-1:0] st,
                                           logic [9:0] used, logic [15:0] len);
    return {own, last, st, used, len};
  endfunction

  function automatic logic [31:0] lane_put(logic [31:0] acc, logic [1:0] lane, logic [7:0] b);
    logic [31:0] r;
    r = acc;
    r[lane*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int MAX_DESC = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAX_DESC+1)-1:0] ring_size,
  input  logic                          advance,
  output logic [$clog2(MAX_DESC)-1:0]   idx
);
  localparam int SW = $clog2(MAX_DESC+1);

  logic [SW-1:0] nxt;
  logic          wrap;
  assign nxt  = SW'(idx) + SW'(1);
  assign wrap = nxt >= ring_size;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + 1'b1;
  end

  a_r10_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_size != 0) |-> (SW'(idx) < ring_size));
  a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (SW'(idx) == ring_size - SW'(1))) |=> (idx == '0));
endmodule

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
  parameter int BUF_BYTES = 512
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               push,
  input  logic                               flush,
  input  logic [7:0]                         byte_in,
  output logic [31:0]                        wdata,
  output logic [$clog2(BUF_BYTES/4)-1:0]     word_ix,
  output logic [$clog2(BUF_BYTES+1)-1:0]     count,
  output logic                               lane_end,
  output logic                               fill_end
);
  localparam int BCW = $clog2(BUF_BYTES+1);
  localparam int WIX = $clog2(BUF_BYTES/4);

  logic [31:0] acc;

  assign wdata    = rxd_pkg::lane_put(acc, count[1:0], byte_in);
  assign word_ix  = WIX'(count >> 2);
  assign lane_end = (count[1:0] == 2'd3);
  assign fill_end = (count == BCW'(BUF_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc   <= '0;
      count <= '0;
    end else if (push) begin
      acc   <= flush ? '0 : wdata;
      count <= count + 1'b1;
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= BCW'(BUF_BYTES));
  a_r4_lanes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (push && flush && !clear) |=> (acc == '0));
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma #(
  parameter int AW        = 16,
  parameter int MAX_DESC  = 64,
  parameter int BUF_BYTES = 512,
  parameter int CW        = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 cfg_ring_base,
  input  logic [$clog2(MAX_DESC+1)-1:0] cfg_ring_size,
  input  logic                          rx_valid,
  output logic                          rx_ready,
  input  logic [7:0]                    rx_data,
  input  logic                          rx_last,
  input  logic [3:0]                    rx_status,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [31:0]                   mem_wdata,
  input  logic                          mem_rvalid,
  input  logic [31:0]                   mem_rdata,
  output logic [CW-1:0]                 drop_count
);
  import rxd_pkg::*;
  localparam int IW  = $clog2(MAX_DESC);
  localparam int BCW = $clog2(BUF_BYTES+1);
  localparam int WIX = $clog2(BUF_BYTES/4);

  rxd_state_e    st;
  logic [IW-1:0] idx;
  logic [AW-1:0] buf_base, desc_addr, ctl_addr;
  logic [15:0]   flen;
  logic          last_q;
  logic [3:0]    stat_q;

  logic            accept, fill_push, flush, buf_done, advance, pk_clear;
  logic [31:0]     pk_wdata, wb_word;
  logic [WIX-1:0]  pk_word_ix;
  logic [BCW-1:0]  pk_count;
  logic            pk_lane_end, pk_fill_end;
  logic            rd_unused;

  assign rd_unused = &{1'b0, mem_rdata[30:AW]};

  assign rx_ready  = (st == S_FILL) || (st == S_DROP);
  assign accept    = rx_valid && rx_ready;
  assign fill_push = accept && (st == S_FILL);
  assign buf_done  = fill_push && (rx_last || pk_fill_end);
  assign flush     = fill_push && (pk_lane_end || rx_last || pk_fill_end);
  assign advance   = (st == S_WB_OWN);
  assign pk_clear  = (st == S_WT_ADDR) && mem_rvalid;

  assign desc_addr = cfg_ring_base + AW'({idx, 1'b0});
  assign ctl_addr  = desc_addr + AW'(1);
  assign wb_word   = ctl_pack(st == S_WB_FIELDS, last_q, last_q ? stat_q : 4'd0,
                              10'(pk_count), last_q ? flen : 16'd0);

  rxd_ring_ptr #(.MAX_DESC(MAX_DESC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_size(cfg_ring_size), .advance(advance), .idx(idx)
  );

  rxd_byte_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pk_clear), .push(fill_push), .flush(flush),
    .byte_in(rx_data), .wdata(pk_wdata), .word_ix(pk_word_ix), .count(pk_count),
    .lane_end(pk_lane_end), .fill_end(pk_fill_end)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ctl_addr;
    mem_wdata = wb_word;
    unique case (st)
      S_RD_CTL:    mem_req = 1'b1;
      S_RD_ADDR:   begin mem_req = 1'b1; mem_addr = desc_addr; end
      S_FILL:      begin
        mem_req   = flush;
        mem_we    = 1'b1;
        mem_addr  = buf_base + AW'(pk_word_ix);
        mem_wdata = pk_wdata;
      end
      S_WB_FIELDS, S_WB_OWN: begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      buf_base   <= '0;
      flen       <= '0;
      last_q     <= 1'b0;
      stat_q     <= '0;
      drop_count <= '0;
    end else begin
      if (fill_push) flen <= flen + 16'd1;
      unique case (st)
        S_IDLE:    if (rx_valid) begin flen <= '0; st <= S_RD_CTL; end
        S_RD_CTL:  st <= S_WT_CTL;
        S_WT_CTL:  if (mem_rvalid) begin
          if (mem_rdata[31]) st <= S_RD_ADDR;
          else begin drop_count <= drop_count + 1'b1; st <= S_DROP; end
        end
        S_RD_ADDR: st <= S_WT_ADDR;
        S_WT_ADDR: if (mem_rvalid) begin buf_base <= mem_rdata[AW-1:0]; st <= S_FILL; end
        S_FILL:    if (buf_done) begin
          last_q <= rx_last;
          stat_q <= rx_status;
          st     <= S_WB_FIELDS;
        end
        S_WB_FIELDS: st <= S_WB_OWN;
        S_WB_OWN:    st <= last_q ? S_IDLE : S_RD_CTL;
        S_DROP:      if (accept && rx_last) st <= S_IDLE;
        default:     st <= S_IDLE;
      endcase
    end
  end

  // named events for the checks below
  logic release_wr, fields_wr, data_wr;
  assign release_wr = mem_req && mem_we && (st == S_WB_OWN);
  assign fields_wr  = mem_req && mem_we && (st == S_WB_FIELDS);
  assign data_wr    = mem_req && mem_we && (st == S_FILL);

  a_r9_fields_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_wr |-> ($past(fields_wr) && $past(mem_wdata[31]) && !mem_wdata[31] &&
                    mem_addr == $past(mem_addr) && mem_wdata[30:0] == $past(mem_wdata[30:0])));
  a_r3_no_write_while_dropping: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_req);
  a_r7_nonlast_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fields_wr && !mem_wdata[30]) |-> (mem_wdata[25:16] == 10'(BUF_BYTES)));
  a_r8_used_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    fields_wr |-> (mem_wdata[25:16] != 10'd0 && mem_wdata[25:16] <= 10'(BUF_BYTES)));
  a_r11_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));
  a_r4_data_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> accept);
endmodule

// File: tb/sim_rxd_ring_dma.sv
`timescale 1ns/1ps
module sim_rxd_ring_dma;
  localparam int AW = 10, MAXD = 8, BB = 16, CW = 16;
  localparam logic [AW-1:0] RB = 10'h040;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [AW-1:0] cfg_ring_base = RB;
  logic [3:0]    cfg_ring_size = 4'd4;
  logic rx_valid = 0, rx_last = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic [3:0] rx_status = 0;
  logic mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [CW-1:0] drop_count;

  rxd_ring_dma #(.AW(AW), .MAX_DESC(MAXD), .BUF_BYTES(BB), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_size(cfg_ring_size),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_status(rx_status), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .drop_count(drop_count));

  logic [31:0] mem [0:1023];
  logic hw_en = 0;
  logic [AW-1:0] hw_a = 0;
  logic [31:0] hw_d = 0;
  logic [AW-1:0] wl_a [0:255];
  logic [31:0]   wl_d [0:255];
  logic [AW-1:0] rl_a [0:255];
  int wcnt = 0, rcnt = 0, total = 0, bad = 0;

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_we;
    mem_rdata  <= mem[mem_addr];
    if (hw_en) mem[hw_a] <= hw_d;
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wl_a[wcnt[7:0]] <= mem_addr; wl_d[wcnt[7:0]] <= mem_wdata; wcnt <= wcnt + 1;
    end
    if (mem_req && !mem_we) begin rl_a[rcnt[7:0]] <= mem_addr; rcnt <= rcnt + 1; end
  end

  function automatic logic [31:0] ctlw(logic own, logic last, logic [3:0] s, int used, int len);
    return {own, last, s, used[9:0], len[15:0]};
  endfunction
  function automatic logic [31:0] word4(logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    total++;
    if (a !== e) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, a, e); end
  endtask

  task automatic hwr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); hw_en = 1; hw_a = a; hw_d = d;
    @(negedge clk); hw_en = 0;
  endtask

  task automatic send_frame(int n, logic [7:0] seed, logic [3:0] s);
    logic rdy;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = seed + 8'(k); rx_last = (k == n-1); rx_status = s;
      rdy = 0;
      while (!rdy) begin
        rdy = rx_ready;
        @(posedge clk);
        if (!rdy) @(negedge clk);
      end
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    repeat (20) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 drop_count", 32'(drop_count), 0);
  endtask

  task automatic t_short;
    int w0, r0;
    w0 = wcnt; r0 = rcnt;
    send_frame(6, 8'h10, 4'd5);
    chk("R2 first read ctl", 32'(rl_a[r0]), 32'(RB + 1));
    chk("R2 second read addr", 32'(rl_a[r0+1]), 32'(RB));
    chk("R4 word0", mem[10'h100], word4(8'h10, 8'h11, 8'h12, 8'h13));
    chk("R4 partial word zero lanes", mem[10'h101], word4(8'h14, 8'h15, 0, 0));
    chk("R8 last ctl", mem[RB+1], ctlw(0, 1, 5, 6, 6));
    chk("R9 write count", 32'(wcnt - w0), 4);
    chk("R9 fields addr", 32'(wl_a[wcnt-2]), 32'(RB + 1));
    chk("R9 fields own set", wl_d[wcnt-2], ctlw(1, 1, 5, 6, 6));
    chk("R9 release addr", 32'(wl_a[wcnt-1]), 32'(RB + 1));
  endtask

  task automatic t_span;
    send_frame(20, 8'h20, 4'd3);
    chk("R6 fresh descriptor offset0", mem[10'h104], word4(8'h20, 8'h21, 8'h22, 8'h23));
    chk("R5 last word of buf1", mem[10'h107], word4(8'h2C, 8'h2D, 8'h2E, 8'h2F));
    chk("R7 nonlast ctl", mem[RB+3], ctlw(0, 0, 0, BB, 0));
    chk("R5 continue buf2", mem[10'h108], word4(8'h30, 8'h31, 8'h32, 8'h33));
    chk("R8 span last ctl", mem[RB+5], ctlw(0, 1, 3, 4, 20));
  endtask

  task automatic t_exact_wrap;
    send_frame(16, 8'h40, 4'hA);
    chk("R8 exact fill ctl", mem[RB+7], ctlw(0, 1, 4'hA, 16, 16));
    chk("R4 exact last word", mem[10'h10F], word4(8'h4C, 8'h4D, 8'h4E, 8'h4F));
    hwr(RB + 1, 32'h8000_0000);
    send_frame(2, 8'h60, 4'd1);
    chk("R10 wrap data", mem[10'h100], word4(8'h60, 8'h61, 0, 0));
    chk("R10 wrap ctl", mem[RB+1], ctlw(0, 1, 1, 2, 2));
  endtask

  task automatic t_not_owned;
    int w0, r0;
    w0 = wcnt; r0 = rcnt;
    send_frame(5, 8'h70, 4'd6);
    chk("R3 no writes", 32'(wcnt - w0), 0);
    chk("R3 drop count", 32'(drop_count), 1);
    chk("R3 polled ctl", 32'(rl_a[r0]), 32'(RB + 3));
    chk("R3 ctl untouched", mem[RB+3], ctlw(0, 0, 0, BB, 0));
    hwr(RB + 3, 32'h8000_0000);
    send_frame(3, 8'h80, 4'd2);
    chk("R3 same descriptor reused", mem[RB+3], ctlw(0, 1, 2, 3, 3));
    chk("R3 reused data", mem[10'h104], word4(8'h80, 8'h81, 8'h82, 0));
  endtask

  task automatic t_mid_drop;
    int w0;
    hwr(RB + 5, 32'h8000_0000);
    w0 = wcnt;
    send_frame(24, 8'h90, 4'd7);
    chk("R11 first buffer ctl", mem[RB+5], ctlw(0, 0, 0, BB, 0));
    chk("R11 first buffer data", mem[10'h10B], word4(8'h9C, 8'h9D, 8'h9E, 8'h9F));
    chk("R11 unowned ctl kept", mem[RB+7], ctlw(0, 1, 4'hA, 16, 16));
    chk("R11 drop count", 32'(drop_count), 2);
    chk("R11 write count", 32'(wcnt - w0), 6);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_BEEF;
    for (int i = 0; i < 4; i++) begin
      mem[RB + 10'(2*i)]     = 32'(10'h100 + 10'(4*i));
      mem[RB + 10'(2*i + 1)] = 32'h8000_0000;
    end
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);
    t_short;
    t_span;
    t_exact_wrap;
    t_not_owned;
    t_mid_drop;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule